// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector with Load Interlock

This block decides, for each of the two ALU operands of an in-order pipeline's execute stage, where the operand value comes from. The choices are the register-file read value, the ALU result waiting in the memory-stage latch, or the result in the writeback latch. An optional fourth path uses the value retired by the previous writeback. That path is generated only when the register file does not write before it reads within a cycle. The block compares the execute-stage source register numbers with the destination number and write flag of each older producer. The youngest matching producer wins.

The block also raises a stall request in the cycle in which a load sits in the execute stage and the instruction right behind it, still in decode, reads the load's destination. The surrounding pipeline holds fetch, decode and register read for that cycle and sends a bubble into execute. One cycle later the loaded data is in the writeback latch and the normal bypass picks it up. The datapath muxes, the ALU, memory and branch handling sit outside this block. The block produces only select codes and the stall request.

Top module: `fwd_unit`

## Requirements
- R1: With no matching producer, each operand select is 2'b00 (register file).
- R2: When the memory-stage producer writes a non-zero register equal to an operand's source and is not a load, that operand's select is 2'b10.
- R3: When the writeback-stage producer writes a non-zero register equal to an operand's source, and R2 does not apply, the select is 2'b01.
- R4: When both the memory-stage and writeback-stage producers match a source, the memory-stage path (2'b10) is chosen.
- R5: A producer whose destination is register 0, or whose write flag is low, is never forwarded from. A source of register 0 always selects 2'b00.
- R6: With RF_WRITE_FIRST=0, a source that matches the writeback destination of the previous cycle (that writeback had its write flag set and a non-zero destination) selects 2'b11 when no younger producer matches. With RF_WRITE_FIRST=1, the code 2'b11 never appears.
- R7: load_stall is high in the same cycle exactly when the execute stage holds a load with write flag set and a non-zero destination, and a decode source flagged as used equals that destination.
- R8: A load in the memory stage is never selected (2'b10 is not produced for it). A matching writeback or retired producer is used instead.
- R9: Reset clears the retired-writeback record, so in the first cycle after reset no operand selects 2'b11.
- R10: The two operand selects are computed independently, and each may name a different path in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | 5 | Decode-stage first source register |
| id_rs2 | input | 5 | Decode-stage second source register |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| ex_rs1 | input | 5 | Execute-stage first source register (operand A) |
| ex_rs2 | input | 5 | Execute-stage second source register (operand B) |
| ex_rd | input | 5 | Execute-stage destination register |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Memory-stage latch destination register |
| mem_we | input | 1 | Memory-stage latch write flag |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Writeback latch destination register |
| wb_we | input | 1 | Writeback latch write flag |
| fwd_sel_a | output | 2 | Operand A source: 00 RF, 10 memory stage, 01 writeback, 11 retired |
| fwd_sel_b | output | 2 | Operand B source, same encoding |
| load_stall | output | 1 | Load-use interlock request |

## Verification
On every cycle, the assertions check the following: register 0 is never bypassed, the memory-stage path wins when it matches, a load in the memory stage is never chosen, and the retired record equals the previous cycle's writeback. They also check that a stall only ever names a load with a real destination. The bench's scenarios show the remaining behaviour. These are the exact code picked for each overlap of producers, the retired path appearing and vanishing with the parameter, the cleared record after reset, and a stall being withheld when the matching source is unused.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
    localparam int REG_AW = 5;
    localparam int N_OPS  = 2;

    typedef logic [REG_AW-1:0] regid_t;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10,
        SRC_RET = 2'b11
    } opsrc_e;

    typedef struct packed {
        regid_t rd;
        logic   we;
        logic   load;
    } producer_t;

    function automatic logic writes_reg(producer_t p, regid_t r);
        return p.we && (p.rd != '0) && (p.rd == r);
    endfunction
endpackage

// File: rtl/fwd_retire.sv
`timescale 1ns/1ps
module fwd_retire
    import fwd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  producer_t wb_p,
    output producer_t ret_p
);
    producer_t ret_q;

    always_ff @(posedge clk) begin
        if (rst) ret_q <= '0;
        else     ret_q <= wb_p;
    end

    assign ret_p = ret_q;

    // R6
    ret_tracks_wb_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (ret_p.rd == $past(wb_p.rd)) && (ret_p.we == $past(wb_p.we)));

    // R9
    ret_cleared_chk: assert property (@(posedge clk)
        rst |=> !ret_p.we);
endmodule

// File: rtl/fwd_operand_sel.sv
`timescale 1ns/1ps
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter bit HAS_RET = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  regid_t    src,
    input  producer_t mem_p,
    input  producer_t wb_p,
    input  producer_t ret_p,
    output opsrc_e    sel
);
    logic hit_mem, hit_wb, hit_ret;

    assign hit_mem = writes_reg(mem_p, src) && !mem_p.load;
    assign hit_wb  = writes_reg(wb_p, src);
    assign hit_ret = HAS_RET && writes_reg(ret_p, src);

    always_comb begin
        if (hit_mem)      sel = SRC_MEM;
        else if (hit_wb)  sel = SRC_WB;
        else if (hit_ret) sel = SRC_RET;
        else              sel = SRC_RF;
    end

    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> (sel == SRC_RF));

    // R4
    younger_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_p.we && !mem_p.load && mem_p.rd == src && src != '0) |-> (sel == SRC_MEM));

    // R8
    no_load_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_MEM) |-> !mem_p.load);

    // R6
    ret_only_if_built_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_RET) |-> (HAS_RET && ret_p.we));
endmodule

// File: rtl/fwd_load_use.sv
`timescale 1ns/1ps
module fwd_load_use
    import fwd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  producer_t ex_p,
    input  regid_t    id_rs1,
    input  regid_t    id_rs2,
    input  logic      id_rs1_used,
    input  logic      id_rs2_used,
    output logic      stall
);
    logic dep1, dep2;

    assign dep1  = id_rs1_used && writes_reg(ex_p, id_rs1);
    assign dep2  = id_rs2_used && writes_reg(ex_p, id_rs2);
    assign stall = ex_p.load && (dep1 || dep2);

    // R7
    stall_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (ex_p.load && ex_p.we && ex_p.rd != '0));

    // R7
    stall_needs_user_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (id_rs1_used || id_rs2_used));
endmodule

// File: rtl/fwd_unit.sv
`timescale 1ns/1ps
module fwd_unit
    import fwd_pkg::*;
#(
    parameter bit RF_WRITE_FIRST = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [fwd_pkg::REG_AW-1:0] id_rs1,
    input  logic [fwd_pkg::REG_AW-1:0] id_rs2,
    input  logic                     id_rs1_used,
    input  logic                     id_rs2_used,
    input  logic [fwd_pkg::REG_AW-1:0] ex_rs1,
    input  logic [fwd_pkg::REG_AW-1:0] ex_rs2,
    input  logic [fwd_pkg::REG_AW-1:0] ex_rd,
    input  logic                     ex_we,
    input  logic                     ex_load,
    input  logic [fwd_pkg::REG_AW-1:0] mem_rd,
    input  logic                     mem_we,
    input  logic                     mem_load,
    input  logic [fwd_pkg::REG_AW-1:0] wb_rd,
    input  logic                     wb_we,
    output logic [1:0]               fwd_sel_a,
    output logic [1:0]               fwd_sel_b,
    output logic                     load_stall
);
    localparam bit HAS_RET = !RF_WRITE_FIRST;

    producer_t ex_p, mem_p, wb_p, ret_p;
    regid_t    src_v [N_OPS];
    opsrc_e    sel_v [N_OPS];

    assign ex_p  = '{rd: ex_rd,  we: ex_we,  load: ex_load};
    assign mem_p = '{rd: mem_rd, we: mem_we, load: mem_load};
    assign wb_p  = '{rd: wb_rd,  we: wb_we,  load: 1'b0};

    assign src_v[0] = ex_rs1;
    assign src_v[1] = ex_rs2;

    generate
        if (HAS_RET) begin : g_ret
            fwd_retire u_ret (
                .clk   (clk),
                .rst   (rst),
                .wb_p  (wb_p),
                .ret_p (ret_p)
            );
        end else begin : g_noret
            assign ret_p = '0;
        end
    endgenerate

    generate
        for (genvar op = 0; op < N_OPS; op++) begin : g_op
            fwd_operand_sel #(.HAS_RET(HAS_RET)) u_sel (
                .clk   (clk),
                .rst   (rst),
                .src   (src_v[op]),
                .mem_p (mem_p),
                .wb_p  (wb_p),
                .ret_p (ret_p),
                .sel   (sel_v[op])
            );
        end
    endgenerate

    fwd_load_use u_lu (
        .clk         (clk),
        .rst         (rst),
        .ex_p        (ex_p),
        .id_rs1      (id_rs1),
        .id_rs2      (id_rs2),
        .id_rs1_used (id_rs1_used),
        .id_rs2_used (id_rs2_used),
        .stall       (load_stall)
    );

    assign fwd_sel_a = sel_v[0];
    assign fwd_sel_b = sel_v[1];

    // R10
    ops_independent_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_rs1 != ex_rs2 && mem_we && !mem_load && mem_rd == ex_rs1 && ex_rs1 != '0)
            |-> (fwd_sel_a == 2'b10 && fwd_sel_b != 2'b10));
endmodule

// File: tb/fwd_unit_test.sv
`timescale 1ns/1ps
module fwd_unit_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic id_rs1_used, id_rs2_used, ex_we, ex_load, mem_we, mem_load, wb_we;
    logic [1:0] sel_a, sel_b, sel_a_wf, sel_b_wf;
    logic stall, stall_wf;

    fwd_unit uut (
        .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
        .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we), .mem_load(mem_load),
        .wb_rd(wb_rd), .wb_we(wb_we),
        .fwd_sel_a(sel_a), .fwd_sel_b(sel_b), .load_stall(stall));

    fwd_unit #(.RF_WRITE_FIRST(1'b1)) uut_wf (
        .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
        .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we), .mem_load(mem_load),
        .wb_rd(wb_rd), .wb_we(wb_we),
        .fwd_sel_a(sel_a_wf), .fwd_sel_b(sel_b_wf), .load_stall(stall_wf));

    typedef struct {
        string      tag;
        logic [1:0] a, b, a_wf;
        logic       st;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // staged stimulus
    logic [4:0] s_id1, s_id2, s_ex1, s_ex2, s_exrd, s_memrd, s_wbrd;
    logic s_u1, s_u2, s_exwe, s_exld, s_memwe, s_memld, s_wbwe, s_rst;
    // bench record of the previous cycle's writeback
    logic [4:0] prev_rd;
    logic       prev_we;

    task automatic clear();
        s_id1 = 0; s_id2 = 0; s_ex1 = 0; s_ex2 = 0; s_exrd = 0; s_memrd = 0; s_wbrd = 0;
        s_u1 = 0; s_u2 = 0; s_exwe = 0; s_exld = 0; s_memwe = 0; s_memld = 0; s_wbwe = 0;
        s_rst = 0;
    endtask

    function automatic logic [1:0] model(input logic [4:0] s, input bit ret_on);
        if (s != 0 && s_memwe && !s_memld && s_memrd == s) return 2'b10;
        if (s != 0 && s_wbwe && s_wbrd == s)               return 2'b01;
        if (ret_on && s != 0 && prev_we && prev_rd == s)   return 2'b11;
        return 2'b00;
    endfunction

    task automatic step(input string tag);
        exp_t e;
        @(negedge clk);
        rst = s_rst;
        id_rs1 = s_id1; id_rs2 = s_id2; id_rs1_used = s_u1; id_rs2_used = s_u2;
        ex_rs1 = s_ex1; ex_rs2 = s_ex2; ex_rd = s_exrd; ex_we = s_exwe; ex_load = s_exld;
        mem_rd = s_memrd; mem_we = s_memwe; mem_load = s_memld;
        wb_rd = s_wbrd; wb_we = s_wbwe;
        if (!s_rst) begin
            e.tag  = tag;
            e.a    = model(s_ex1, 1'b1);
            e.b    = model(s_ex2, 1'b1);
            e.a_wf = model(s_ex1, 1'b0);
            e.st   = s_exld && s_exwe && s_exrd != 0 &&
                     ((s_u1 && s_id1 == s_exrd) || (s_u2 && s_id2 == s_exrd));
            expq.push_back(e);
        end
        prev_rd = s_rst ? 5'd0 : s_wbrd;
        prev_we = s_rst ? 1'b0 : s_wbwe;
    endtask

    task automatic cmp(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                cmp(e.tag, "sel_a", sel_a, e.a);
                cmp(e.tag, "sel_b", sel_b, e.b);
                cmp(e.tag, "sel_a_wf", sel_a_wf, e.a_wf);
                cmp(e.tag, "stall", {1'b0, stall}, {1'b0, e.st});
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        prev_rd = 0; prev_we = 0;
        clear(); s_rst = 1; s_wbrd = 7; s_wbwe = 1;
        step("R9"); step("R9");
        // R9: first cycle after reset, record must be empty
        clear(); s_ex1 = 7; s_ex2 = 7;
        step("R9");
        // R1: nothing matches
        clear(); s_ex1 = 3; s_ex2 = 4; s_memrd = 9; s_memwe = 1; s_wbrd = 12; s_wbwe = 1;
        step("R1");
        // R2: memory-stage ALU result
        clear(); s_ex1 = 3; s_ex2 = 4; s_memrd = 3; s_memwe = 1;
        step("R2");
        // R3: writeback result
        clear(); s_ex1 = 2; s_ex2 = 4; s_wbrd = 4; s_wbwe = 1;
        step("R3");
        // R6: retired path on default, absent with write-first register file
        clear(); s_ex1 = 4; s_ex2 = 4;
        step("R6");
        // R4: both stages match, memory stage wins
        clear(); s_ex1 = 5; s_ex2 = 5; s_memrd = 5; s_memwe = 1; s_wbrd = 5; s_wbwe = 1;
        step("R4");
        // R5: register zero never forwarded
        clear(); s_memrd = 0; s_memwe = 1; s_wbrd = 0; s_wbwe = 1;
        step("R5");
        // R5: write flag low blocks forwarding
        clear(); s_ex1 = 6; s_ex2 = 6; s_memrd = 6; s_wbrd = 6;
        step("R5");
        // R8: load in memory stage skipped, writeback used
        clear(); s_ex1 = 7; s_ex2 = 7; s_memrd = 7; s_memwe = 1; s_memld = 1; s_wbrd = 7; s_wbwe = 1;
        step("R8");
        // R8: load in memory stage alone gives register file
        clear(); s_ex1 = 8; s_memrd = 8; s_memwe = 1; s_memld = 1;
        step("R8");
        // R10: operands take different paths
        clear(); s_ex1 = 9; s_ex2 = 10; s_memrd = 9; s_memwe = 1; s_wbrd = 10; s_wbwe = 1;
        step("R10");
        // R7: load followed by user of first source
        clear(); s_exrd = 11; s_exwe = 1; s_exld = 1; s_id1 = 11; s_u1 = 1;
        step("R7");
        // R7: matching source flagged unused
        clear(); s_exrd = 11; s_exwe = 1; s_exld = 1; s_id2 = 11; s_u2 = 0; s_id1 = 3; s_u1 = 1;
        step("R7");
        // R7: load to register zero
        clear(); s_exrd = 0; s_exwe = 1; s_exld = 1; s_id1 = 0; s_u1 = 1;
        step("R7");
        // R7: non-load producer does not stall
        clear(); s_exrd = 13; s_exwe = 1; s_id1 = 13; s_u1 = 1;
        step("R7");
        // R7: second source match stalls
        clear(); s_exrd = 14; s_exwe = 1; s_exld = 1; s_id2 = 14; s_u2 = 1; s_wbrd = 12; s_wbwe = 1;
        step("R7");
        // R6: writeback outranks retired record
        clear(); s_ex1 = 12; s_ex2 = 12; s_wbrd = 12; s_wbwe = 1;
        step("R6");
        // R6: retired match alone on operand B only
        clear(); s_ex1 = 1; s_ex2 = 12;
        step("R6");
        clear();
        step("R1");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule